// File: doc/BRIEF.md
# Alias-Checking Tag Controller for a Virtually Indexed, Physically Tagged L1 Data Cache

This block manages the tag side of a 32 KB, 2-way L1 data cache with 64-byte lines. The cache has 256 sets, and the set is chosen by virtual address bits [13:6]. The page offset covers only bits [11:0], so the two top index bits, [13:12], come from the untranslated virtual page number. Each way stores the full physical frame number, PA[40:12], as its tag. The block also keeps a valid bit and a dirty bit per way and one replacement bit per set. Line data, address translation and refill from memory are handled elsewhere.

A single physical line can therefore be placed in any of four sets. These sets share index bits [11:6] and differ only in bits [13:12]. The block deals with this in two operations. A fill first walks all four candidate sets and evicts any copy of the same frame before it writes the new line. An incoming snoop carries only a physical line address, so it walks the same four sets, invalidates every copy it finds and reports whether any of them held modified data. Each walk reads one set per cycle. No new request is accepted until the walk is finished.

The controller is a four-state machine:
- `ST_IDLE` accepts a request.
  - A read or write is answered from `ST_IDLE` directly.
  - A fill moves to `ST_ALIAS`.
  - A snoop moves to `ST_SNOOP`.
- `ST_ALIAS` probes one candidate set per cycle. After the fourth probe it moves to `ST_FILL`.
- `ST_FILL` writes the chosen way and returns to `ST_IDLE`.
- `ST_SNOOP` probes one candidate set per cycle. After the fourth probe it returns to `ST_IDLE`.

Top module: `vipt_alias_ctrl`

## Requirements
- R1: After reset every way is invalid and every replacement bit is 0. `req_ready` is 1, and `rsp_valid` and `wb_valid` are 0.
- R2: A read (`req_op`=0) or write (`req_op`=1) accepted in a cycle gives `rsp_valid` in the next cycle.
  - It hits when a valid way of set `req_va_idx` holds tag `req_line[34:6]`.
  - `rsp_way` is the hitting way. `rsp_dirty` is that way's dirty bit before the access.
  - A write hit sets the dirty bit. A miss changes nothing.
- R3: Each set has a replacement bit that names the way to be replaced next.
  - A read or write hit sets the bit to the other way.
  - A fill places the line in way 0 if way 0 is invalid, otherwise in way 1 if way 1 is invalid, otherwise in the way the bit names. It then sets the bit to the other way.
- R4: A fill (`req_op`=2) probes sets {k, `req_line[5:0]`} for k = 0,1,2,3, one per cycle, and invalidates any valid way whose tag equals the new tag. It then writes the line into set `req_va_idx` with dirty bit `req_fill_dirty`.
  - The response comes 6 cycles after acceptance.
  - `rsp_hit` is 1 when an alias copy was evicted. `rsp_dirty` is 1 when that copy was dirty. `rsp_way` is the way written.
- R5: `wb_valid` pulses for one cycle, with `wb_line` set to the line's PA[40:6], in the cycle where a dirty line is about to lose its validity. This covers a dirty alias evicted during a fill and a dirty victim replaced by a fill. The alias pulse comes before the victim pulse.
- R6: A snoop (`req_op`=3) probes the same four sets, one per cycle, and invalidates every matching way.
  - The response comes 5 cycles after acceptance. `rsp_hit` is 1 if any copy matched. `rsp_dirty` is 1 if any matching copy was dirty.
  - A snoop raises no writeback and leaves the replacement bits alone.
- R7: `req_ready` is 0 from the acceptance of a fill or snoop until its response appears.
  - A request presented while `req_ready` is 0 is ignored and produces no response.
  - Exactly one response is produced per accepted request.
- R8: After any fill, at most one valid copy of a physical line exists across its four candidate sets. A read through any other alias index misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request is taken on this edge |
| req_op | input | 2 | 0 read, 1 write, 2 fill, 3 snoop |
| req_va_idx | input | 8 | Virtual set index VA[13:6]; not used by a snoop |
| req_line | input | 35 | Physical line address PA[40:6] |
| req_fill_dirty | input | 1 | Dirty state of a line being filled |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Lookup hit, alias evicted, or snoop match |
| rsp_way | output | 1 | Way hit or way written |
| rsp_dirty | output | 1 | Dirty state of the hit, evicted or snooped copy |
| wb_valid | output | 1 | Writeback request for a dirty line being dropped |
| wb_line | output | 35 | PA[40:6] of the line to write back |

## Verification
The bench targets the following corner cases:
- A fill whose alias sits in a different set. A controller that probed only the target set would leave two copies, and a later read through the old index would wrongly hit.
- A fill whose alias is dirty. A missing or late writeback pulse, or a pulse carrying the wrong line, is reported by the pulse count and the address comparison.
- A full set that forces replacement by the replacement bit, including a dirty victim. Here a wrong bit update shows up as a wrong `rsp_way`.
- Snoops that match in sets other than the one named by their low index bits.
- Requests driven while the controller is busy. A design that did not stall would give an extra or early response.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    // Geometry of the cache this controller serves.
    localparam int PA_W     = 41;
    localparam int LINE_OFF = 6;
    localparam int PAGE_OFF = 12;
    localparam int SET_BITS = 8;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_FILL  = 2'd2,
        OP_SNOOP = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIAS = 2'd1,
        ST_FILL  = 2'd2,
        ST_SNOOP = 2'd3
    } state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int SET_BITS = 8,
    parameter int TAG_W    = 29,
    parameter int WAYS     = 2,
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int NSETS   = 1 << SET_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_BITS-1:0]         idx,
    input  logic [WAYS-1:0]             clr_valid,
    input  logic [WAYS-1:0]             set_dirty,
    input  logic                        fill_en,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic                        fill_dirty,
    input  logic                        lru_we,
    input  logic [WAY_W-1:0]            lru_val,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAY_W-1:0]            rd_lru
);
    logic [WAYS-1:0]            valid_q [NSETS];
    logic [WAYS-1:0]            dirty_q [NSETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [NSETS];
    logic [WAY_W-1:0]           lru_q   [NSETS];

    // State bits with reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                lru_q[s]   <= '0;
            end
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (clr_valid[w]) valid_q[idx][w] <= 1'b0;
                if (set_dirty[w]) dirty_q[idx][w] <= 1'b1;
                if (fill_en && (fill_way == WAY_W'(w))) begin
                    valid_q[idx][w] <= 1'b1;
                    dirty_q[idx][w] <= fill_dirty;
                end
            end
            if (lru_we) lru_q[idx] <= lru_val;
        end
    end

    // Tags need no reset: they are qualified by the valid bits.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx][fill_way] <= fill_tag;
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_lru   = lru_q[idx];

    // A clear command must only ever target a live line (R5: the pulse
    // precedes the clear, so the line is still valid in that cycle).
    for (genvar g = 0; g < WAYS; g++) begin : g_chk
        a_r5_clear_live_line: assert property (@(posedge clk) disable iff (!rst_n)
            clr_valid[g] |-> valid_q[idx][g]);
    end
endmodule

// File: rtl/vipt_way_cmp.sv
module vipt_way_cmp #(
    parameter int TAG_W  = 29,
    parameter int WAYS   = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            cmp_tag,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        hit_any,
    output logic [WAY_W-1:0]            hit_way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign hit_vec[g] = valid[g] && (tags[g] == cmp_tag);
    end

    assign hit_any = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/vipt_victim_pick.sv
module vipt_victim_pick #(
    parameter int WAYS   = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAY_W-1:0] lru,
    output logic [WAY_W-1:0] victim
);
    // Lowest-numbered free way wins; a full set falls back to the
    // replacement pointer.
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = lru;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vipt_alias_ctrl.sv
module vipt_alias_ctrl
    import vipt_pkg::*;
#(
    parameter int PA_BITS    = PA_W,
    parameter int IDX_BITS   = SET_BITS,
    parameter int LINE_BITS  = LINE_OFF,
    parameter int PAGE_BITS  = PAGE_OFF,
    localparam int LINE_W    = PA_BITS - LINE_BITS,
    localparam int TAG_W     = PA_BITS - PAGE_BITS,
    localparam int LOW_W     = PAGE_BITS - LINE_BITS,
    localparam int ALIAS_W   = IDX_BITS - LOW_W,
    localparam int WAYS      = 2,
    localparam int WAY_W     = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [IDX_BITS-1:0] req_va_idx,
    input  logic [LINE_W-1:0]   req_line,
    input  logic                req_fill_dirty,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [WAY_W-1:0]    rsp_way,
    output logic                rsp_dirty,
    output logic                wb_valid,
    output logic [LINE_W-1:0]   wb_line
);
    state_e               state_q, state_d;
    logic [ALIAS_W-1:0]   cnt_q;
    logic [IDX_BITS-1:0]  va_idx_q;
    logic [LINE_W-1:0]    line_q;
    logic                 fdirty_q;
    logic                 acc_hit_q, acc_dirty_q;

    op_e                  op_in;
    logic                 accept;
    logic                 cnt_last;
    logic                 is_lookup;

    // Tag store interface.
    logic [IDX_BITS-1:0]        arr_idx;
    logic [TAG_W-1:0]           cmp_tag;
    logic [WAYS-1:0]            rd_valid, rd_dirty;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAY_W-1:0]           rd_lru;
    logic [WAYS-1:0]            clr_valid, set_dirty;
    logic                       fill_en, fill_dirty, lru_we;
    logic [WAY_W-1:0]           fill_way, lru_val;
    logic [TAG_W-1:0]           fill_tag;

    // Match and victim results.
    logic [WAYS-1:0]  hit_vec;
    logic             hit_any;
    logic [WAY_W-1:0] hit_way;
    logic             hit_dirty;
    logic [WAY_W-1:0] victim_way;

    assign op_in     = op_e'(req_op);
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cnt_last  = (cnt_q == {ALIAS_W{1'b1}});
    assign is_lookup = (op_in == OP_READ) || (op_in == OP_WRITE);
    assign hit_dirty = hit_any && rd_dirty[hit_way];

    vipt_tag_store #(.SET_BITS(IDX_BITS), .TAG_W(TAG_W), .WAYS(WAYS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (arr_idx),
        .clr_valid  (clr_valid),
        .set_dirty  (set_dirty),
        .fill_en    (fill_en),
        .fill_way   (fill_way),
        .fill_tag   (fill_tag),
        .fill_dirty (fill_dirty),
        .lru_we     (lru_we),
        .lru_val    (lru_val),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty),
        .rd_tag     (rd_tag),
        .rd_lru     (rd_lru)
    );

    vipt_way_cmp #(.TAG_W(TAG_W), .WAYS(WAYS)) u_cmp (
        .valid   (rd_valid),
        .tags    (rd_tag),
        .cmp_tag (cmp_tag),
        .hit_vec (hit_vec),
        .hit_any (hit_any),
        .hit_way (hit_way)
    );

    vipt_victim_pick #(.WAYS(WAYS)) u_victim (
        .valid  (rd_valid),
        .lru    (rd_lru),
        .victim (victim_way)
    );

    // Array index and compare tag follow the phase of the walk.
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                arr_idx = req_va_idx;
                cmp_tag = req_line[LINE_W-1:LOW_W];
            end
            ST_ALIAS, ST_SNOOP: begin
                arr_idx = {cnt_q, line_q[LOW_W-1:0]};
                cmp_tag = line_q[LINE_W-1:LOW_W];
            end
            ST_FILL: begin
                arr_idx = va_idx_q;
                cmp_tag = line_q[LINE_W-1:LOW_W];
            end
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && (op_in == OP_FILL))  state_d = ST_ALIAS;
                if (accept && (op_in == OP_SNOOP)) state_d = ST_SNOOP;
            end
            ST_ALIAS: if (cnt_last) state_d = ST_FILL;
            ST_FILL:  state_d = ST_IDLE;
            ST_SNOOP: if (cnt_last) state_d = ST_IDLE;
        endcase
    end

    // State register and walk bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            va_idx_q    <= '0;
            line_q      <= '0;
            fdirty_q    <= 1'b0;
            acc_hit_q   <= 1'b0;
            acc_dirty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q       <= '0;
                va_idx_q    <= req_va_idx;
                line_q      <= req_line;
                fdirty_q    <= req_fill_dirty;
                acc_hit_q   <= 1'b0;
                acc_dirty_q <= 1'b0;
            end else if ((state_q == ST_ALIAS) || (state_q == ST_SNOOP)) begin
                cnt_q       <= cnt_q + 1'b1;
                acc_hit_q   <= acc_hit_q | hit_any;
                acc_dirty_q <= acc_dirty_q | hit_dirty;
            end
        end
    end

    // Array commands and writeback strobe.
    always_comb begin
        clr_valid  = '0;
        set_dirty  = '0;
        fill_en    = 1'b0;
        fill_way   = victim_way;
        fill_tag   = line_q[LINE_W-1:LOW_W];
        fill_dirty = fdirty_q;
        lru_we     = 1'b0;
        lru_val    = '0;
        wb_valid   = 1'b0;
        wb_line    = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && is_lookup && hit_any) begin
                    lru_we  = 1'b1;
                    lru_val = ~hit_way;
                    if (op_in == OP_WRITE) set_dirty[hit_way] = 1'b1;
                end
            end
            ST_ALIAS: begin
                clr_valid = hit_vec;
                wb_valid  = hit_dirty;
                wb_line   = line_q;
            end
            ST_SNOOP: begin
                clr_valid = hit_vec;
            end
            ST_FILL: begin
                fill_en  = 1'b1;
                lru_we   = 1'b1;
                lru_val  = ~victim_way;
                wb_valid = rd_valid[victim_way] && rd_dirty[victim_way];
                wb_line  = {rd_tag[victim_way], va_idx_q[LOW_W-1:0]};
            end
        endcase
    end

    // Registered response.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_dirty <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && is_lookup) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= hit_any;
                rsp_way   <= hit_way;
                rsp_dirty <= hit_dirty;
            end else if ((state_q == ST_SNOOP) && cnt_last) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= acc_hit_q | hit_any;
                rsp_way   <= '0;
                rsp_dirty <= acc_dirty_q | hit_dirty;
            end else if (state_q == ST_FILL) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= acc_hit_q;
                rsp_way   <= victim_way;
                rsp_dirty <= acc_dirty_q;
            end
        end
    end

    // R2: a lookup is answered in the very next cycle.
    a_r2_lookup_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_lookup) |=> rsp_valid);

    // R7: once a walk starts, the next cycle refuses requests.
    a_r7_walk_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_lookup) |=> !req_ready);

    // R8: the single-copy invariant means at most one way matches a probe.
    a_r8_one_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ALIAS) || (state_q == ST_SNOOP)) |-> ($countones(hit_vec) <= 1));

    // R4: the write of the new line always follows the alias walk.
    a_r4_fill_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> ($past(state_q) == ST_ALIAS));

    // R3: a free way is always preferred over displacing a live line.
    a_r3_free_way_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FILL) && !(&rd_valid)) |-> !rd_valid[victim_way]);

    // R5/R6: writebacks only come from fill activity, never from a snoop.
    a_r5_wb_from_fill_only: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ((state_q == ST_ALIAS) || (state_q == ST_FILL)));

    a_r6_snoop_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SNOOP) |-> !wb_valid);
endmodule

// File: tb/vipt_alias_ctrl_tb.sv
`timescale 1ns/1ps
module vipt_alias_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_va_idx = 8'd0;
    logic [34:0] req_line = 35'd0;
    logic        req_fill_dirty = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_dirty, wb_valid;
    logic [0:0]  rsp_way;
    logic [34:0] wb_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vipt_alias_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_op         (req_op),
        .req_va_idx     (req_va_idx),
        .req_line       (req_line),
        .req_fill_dirty (req_fill_dirty),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_way        (rsp_way),
        .rsp_dirty      (rsp_dirty),
        .wb_valid       (wb_valid),
        .wb_line        (wb_line)
    );

    // Reference model of the tag state.
    bit          m_valid [256][2];
    bit          m_dirty [256][2];
    logic [28:0] m_tag   [256][2];
    bit          m_lru   [256];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input int op, input logic [7:0] va, input logic [34:0] line,
                          input bit fd, input string lbl, input bit inject);
        logic [28:0] t;
        logic [5:0]  lo;
        bit          e_hit, e_dirty;
        int          e_way, e_lat, e_wbn, wbn, got_lat, v;
        logic [34:0] e_wb [2];
        logic [34:0] wbs  [2];
        bit          g_hit, g_dirty;
        int          g_way;
        t = line[34:6]; lo = line[5:0];
        e_hit = 0; e_dirty = 0; e_way = 0; e_wbn = 0; wbn = 0; got_lat = 0;
        g_hit = 0; g_dirty = 0; g_way = 0;
        e_wb[0] = '0; e_wb[1] = '0; wbs[0] = '0; wbs[1] = '0;
        if (op <= 1) begin
            e_lat = 1;
            for (int w = 0; w < 2; w++)
                if (m_valid[va][w] && m_tag[va][w] == t) begin
                    e_hit = 1; e_way = w; e_dirty = m_dirty[va][w];
                end
            if (e_hit) begin
                m_lru[va] = (e_way == 0);
                if (op == 1) m_dirty[va][e_way] = 1;
            end
        end else begin
            e_lat = (op == 2) ? 6 : 5;
            for (int k = 0; k < 4; k++) begin
                logic [7:0] s;
                s = {k[1:0], lo};
                for (int w = 0; w < 2; w++)
                    if (m_valid[s][w] && m_tag[s][w] == t) begin
                        e_hit = 1;
                        if (m_dirty[s][w]) begin
                            e_dirty = 1;
                            if (op == 2 && e_wbn < 2) begin e_wb[e_wbn] = line; e_wbn++; end
                        end
                        m_valid[s][w] = 0;
                    end
            end
            if (op == 2) begin
                if (!m_valid[va][0]) v = 0;
                else if (!m_valid[va][1]) v = 1;
                else v = m_lru[va];
                if (m_valid[va][v] && m_dirty[va][v] && e_wbn < 2) begin
                    e_wb[e_wbn] = {m_tag[va][v], va[5:0]}; e_wbn++;
                end
                m_valid[va][v] = 1; m_dirty[va][v] = fd; m_tag[va][v] = t;
                m_lru[va] = (v == 0);
                e_way = v;
            end
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R7", "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_op = op[1:0]; req_va_idx = va;
        req_line = line; req_fill_dirty = fd;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (wb_valid) begin
                if (wbn < 2) wbs[wbn] = wb_line;
                wbn++;
            end
            if (rsp_valid) begin
                got_lat = n; g_hit = rsp_hit; g_dirty = rsp_dirty; g_way = int'(rsp_way);
                break;
            end
            if (op >= 2)
                chk(req_ready == 1'b0, "R7", "ready during walk", 64'(req_ready), 64'd0);
            if (inject) begin
                req_valid = 1'b1; req_op = 2'd0;
                req_va_idx = va; req_line = line;
            end
        end
        req_valid = 1'b0;
        chk(got_lat == e_lat, (op <= 1) ? "R2" : (op == 2) ? "R4" : "R6",
            "response latency", 64'(got_lat), 64'(e_lat));
        chk(g_hit == e_hit, lbl, "hit", 64'(g_hit), 64'(e_hit));
        chk(g_dirty == e_dirty, lbl, "dirty", 64'(g_dirty), 64'(e_dirty));
        if (op <= 1 && e_hit) chk(g_way == e_way, lbl, "hit way", 64'(g_way), 64'(e_way));
        if (op == 2) chk(g_way == e_way, "R3", "fill way", 64'(g_way), 64'(e_way));
        chk(wbn == e_wbn, (op == 3) ? "R6" : "R5", "writeback count", 64'(wbn), 64'(e_wbn));
        for (int i = 0; i < 2; i++)
            if (i < e_wbn && i < wbn)
                chk(wbs[i] == e_wb[i], "R5", "writeback line", 64'(wbs[i]), 64'(e_wb[i]));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R7", "no extra response", 64'(rsp_valid), 64'd0);
        chk(wb_valid == 1'b0, "R5", "no stray writeback", 64'(wb_valid), 64'd0);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    localparam logic [28:0] TAGS [4] = '{29'h1ABCD123, 29'h0000_0F0F, 29'h1234_5678, 29'h0FED_CBA9};
    localparam logic [5:0]  LOWS [2] = '{6'h05, 6'h2A};

    initial begin
        logic [34:0] la, lb, lc;
        for (int s = 0; s < 256; s++) begin
            m_lru[s] = 0;
            for (int w = 0; w < 2; w++) begin m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = '0; end
        end
        void'($urandom(32'd20240517));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset.
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp after reset", 64'(rsp_valid), 64'd0);
        chk(wb_valid == 1'b0, "R1", "wb after reset", 64'(wb_valid), 64'd0);

        la = {TAGS[0], LOWS[0]};
        lb = {TAGS[1], LOWS[0]};
        lc = {TAGS[2], LOWS[0]};
        run_op(0, {2'b01, LOWS[0]}, la, 0, "R1", 0);    // empty after reset
        run_op(2, {2'b01, LOWS[0]}, la, 0, "R4", 0);    // clean fill, no alias
        run_op(0, {2'b01, LOWS[0]}, la, 0, "R2", 0);    // read hit
        run_op(1, {2'b01, LOWS[0]}, la, 0, "R2", 0);    // write hit marks dirty
        run_op(2, {2'b00, LOWS[0]}, la, 0, "R4", 0);    // dirty alias in set 01 evicted
        run_op(0, {2'b01, LOWS[0]}, la, 0, "R8", 0);    // old index must miss
        run_op(0, {2'b00, LOWS[0]}, la, 0, "R8", 0);    // new index hits
        run_op(2, {2'b00, LOWS[0]}, lb, 1, "R4", 0);    // second way, dirty
        run_op(0, {2'b00, LOWS[0]}, la, 0, "R3", 0);    // touch la, lb becomes victim
        run_op(2, {2'b00, LOWS[0]}, lc, 0, "R3", 0);    // evicts dirty lb
        run_op(3, 8'h00, la, 0, "R6", 1);               // snoop with busy traffic
        run_op(0, {2'b00, LOWS[0]}, la, 0, "R6", 0);    // gone after snoop
        run_op(3, 8'h00, lb, 0, "R6", 0);               // snoop miss

        for (int i = 0; i < 400; i++) begin
            int r, op;
            logic [34:0] ln;
            logic [7:0]  va;
            r  = $urandom % 10;
            op = (r < 4) ? 0 : (r < 6) ? 1 : (r < 9) ? 2 : 3;
            ln = {TAGS[$urandom % 4], LOWS[$urandom % 2]};
            va = {2'($urandom % 4), ln[5:0]};
            run_op(op, va, ln, 1'($urandom % 2),
                   (op <= 1) ? "R2" : (op == 2) ? "R4" : "R6", ($urandom % 4) == 0);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            summary();
            $finish;
        end
    end
endmodule